// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a row of boundary scan cells that sits between a device's pins and its core logic. Each cell holds two flops. The first is a capture/shift stage, which either records the value at its parallel input or takes the bit from its upstream neighbour. The second is an update stage, which holds a value that the cell can drive onto its parallel output. The cells form one serial path. The test data input feeds cell 0, and the last cell drives the test data output.

A test controller elsewhere drives four shared controls: shift, capture, update and mode. With mode low, every cell passes its parallel input straight through, so the pins work normally. With mode high, each parallel output carries the cell's update stage instead. Because shifting happens in the first stage only, the outputs keep their values until an update strobe copies the new pattern across. Pin types map onto cells at integration time: an input or output pin takes one cell, a tri-state output takes two (data and enable), and a bidirectional pin takes three.

Top module: `bsc_chain`

## Requirements
- R1: While rst_n is low, every capture stage and every update stage clears to 0. Just after reset, par_out equals par_in with mode low and is all zeros with mode high; tdo is 0.
- R2: With mode low, par_out[i] equals par_in[i] for every cell, whatever the other controls are doing.
- R3: On a rising tck edge with shift high, cell 0 loads tdi and cell i loads cell i-1. tdo is the capture stage of cell N_CELLS-1, so a bit presented on tdi appears on tdo after N_CELLS shifting edges.
- R4: When shift and capture are both high on a rising edge, the shift wins and par_in is not loaded.
- R5: On a rising tck edge with capture high and shift low, every capture stage loads its own par_in bit.
- R6: On a falling tck edge with update high, every update stage copies its capture stage. With mode high, par_out then shows that value.
- R7: With mode high, par_out does not change during shift or capture activity until an update strobe occurs.
- R8: On a rising edge with neither shift nor capture high, the capture stages hold their values, so tdo is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; capture/shift stages on rising edge, update stages on falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data into cell 0 |
| shift | input | 1 | Select serial path into the capture stages |
| capture | input | 1 | Load par_in into the capture stages |
| update | input | 1 | Copy capture stages into update stages on falling edge |
| mode | input | 1 | 0: pass par_in through; 1: drive update stages |
| par_in | input | N_CELLS | Parallel inputs, one per cell |
| par_out | output | N_CELLS | Parallel outputs, one per cell |
| tdo | output | 1 | Serial data out of the last cell |

## Verification
Shift and capture can both be asserted on the same rising edge. The bench does this with par_in all ones and tdi held at 0. It then shifts the chain out and checks that tdo follows the shifted pattern and never shows the captured ones. A second overlap is an update falling half a cycle after a shifting edge. The update stages must take the post-shift contents, and the bench checks this on par_out with mode high.

// File: rtl/bsc_chain.sv
module bsc_chain #(
  parameter int N_CELLS = 8
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tdi,
  input  logic               shift,
  input  logic               capture,
  input  logic               update,
  input  logic               mode,
  input  logic [N_CELLS-1:0] par_in,
  output logic [N_CELLS-1:0] par_out,
  output logic               tdo
);

  logic [N_CELLS-1:0] cap_q;
  logic [N_CELLS-1:0] upd_q;
  logic [N_CELLS:0]   sin;

  assign sin[0] = tdi;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    logic c_q;
    logic u_q;

    always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       c_q <= 1'b0;
      else if (shift)   c_q <= sin[i];
      else if (capture) c_q <= par_in[i];
    end

    always_ff @(negedge tck or negedge rst_n) begin
      if (!rst_n)      u_q <= 1'b0;
      else if (update) u_q <= c_q;
    end

    assign cap_q[i]   = c_q;
    assign upd_q[i]   = u_q;
    assign sin[i+1]   = c_q;
    assign par_out[i] = mode ? u_q : par_in[i];
  end

  assign tdo = sin[N_CELLS];

endmodule

// File: rtl/bsc_chain_chk.sv
module bsc_chain_chk #(
  parameter int N_CELLS = 8
) (
  input logic               tck,
  input logic               rst_n,
  input logic               tdi,
  input logic               shift,
  input logic               capture,
  input logic               update,
  input logic [N_CELLS-1:0] par_in,
  input logic [N_CELLS-1:0] cap,
  input logic [N_CELLS-1:0] upd
);

  assert_reset_clear_R1: assert property (@(posedge tck)
    !rst_n |-> (cap == '0 && upd == '0));

  assert_shift_move_R3: assert property (@(posedge tck) disable iff (!rst_n)
    shift |=> (cap == {$past(cap[N_CELLS-2:0]), $past(tdi)}));

  assert_capture_load_R5: assert property (@(posedge tck) disable iff (!rst_n)
    (capture && !shift) |=> (cap == $past(par_in)));

  assert_hold_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (!capture && !shift) |=> $stable(cap));

  assert_update_only_R6: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(upd) |-> update);

endmodule

bind bsc_chain bsc_chain_chk #(.N_CELLS(N_CELLS)) u_chk (
  .tck(tck), .rst_n(rst_n), .tdi(tdi), .shift(shift), .capture(capture),
  .update(update), .par_in(par_in), .cap(cap_q), .upd(upd_q)
);

// File: tb/tb_bsc_chain.sv
`timescale 1ns/1ps
module tb_bsc_chain;
  localparam int N = 8;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tdi = 1'b0, shift = 1'b0, capture = 1'b0, update = 1'b0, mode = 1'b0;
  logic [N-1:0] par_in = '0;
  logic [N-1:0] par_out;
  logic tdo;

  always #2.5 tck = ~tck;

  bsc_chain #(.N_CELLS(N)) dut (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .shift(shift), .capture(capture),
    .update(update), .mode(mode), .par_in(par_in), .par_out(par_out), .tdo(tdo)
  );

  typedef struct {
    logic         e_tdo;
    logic [N-1:0] e_po;
    string        tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  logic [N-1:0] cap_m = '0;
  logic [N-1:0] upd_m = '0;

  task automatic step(input logic sh, input logic ca, input logic up, input logic md,
                      input logic [N-1:0] pin, input logic ti, input string tag);
    item_t it;
    @(posedge tck);
    if (shift)        cap_m = {cap_m[N-2:0], tdi};
    else if (capture) cap_m = par_in;
    #1;
    shift = sh; capture = ca; update = up; mode = md; par_in = pin; tdi = ti;
    if (up) upd_m = cap_m;
    it.e_tdo = cap_m[N-1];
    it.e_po  = md ? upd_m : pin;
    it.tag   = tag;
    q.push_back(it);
  endtask

  initial begin
    forever begin
      @(negedge tck);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (tdo !== it.e_tdo) begin
          failures++;
          $display("FAIL %s tdo actual=%b expected=%b", it.tag, tdo, it.e_tdo);
        end
        checks++;
        if (par_out !== it.e_po) begin
          failures++;
          $display("FAIL %s par_out actual=%h expected=%h", it.tag, par_out, it.e_po);
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [N-1:0] pat;
    repeat (3) @(posedge tck);
    #1 rst_n = 1'b1;
    // R1: reset state
    step(0, 0, 0, 0, 8'hA5, 0, "R1");
    step(0, 0, 0, 1, 8'h3C, 0, "R1");
    // R2: pass-through with several patterns, also while shifting
    step(0, 0, 0, 0, 8'h00, 0, "R2");
    step(0, 0, 0, 0, 8'hFF, 1, "R2");
    step(1, 0, 0, 0, 8'h5A, 1, "R2");
    step(1, 0, 0, 0, 8'h96, 0, "R2");
    // R5: capture parallel inputs
    step(0, 1, 0, 1, 8'hC6, 0, "R5");
    step(0, 0, 0, 1, 8'h00, 0, "R5");
    // R8: hold while idle, par_in changing
    step(0, 0, 0, 1, 8'h11, 1, "R8");
    step(0, 0, 0, 1, 8'hEE, 0, "R8");
    // R3 and R7: shift a pattern in with mode high and no update
    pat = 8'hB3;
    for (int k = 0; k < N; k++) step(1, 0, 0, 1, 8'h0F, pat[k], "R3");
    for (int k = 0; k < 2; k++) step(0, 0, 0, 1, 8'hF0, 0, "R7");
    // R6: update copies capture stages, visible with mode high
    step(0, 0, 1, 1, 8'h00, 0, "R6");
    step(0, 0, 0, 1, 8'h00, 0, "R6");
    step(0, 0, 0, 0, 8'h24, 0, "R6");
    // R4: shift and capture together, shift wins
    step(1, 1, 0, 1, 8'hFF, 0, "R4");
    for (int k = 0; k < N; k++) step(1, 0, 0, 1, 8'hFF, 0, "R4");
    // R6: update half a cycle after a shifting edge
    step(1, 0, 0, 1, 8'h00, 1, "R6");
    step(0, 0, 1, 1, 8'h00, 0, "R6");
    step(0, 0, 0, 1, 8'h00, 0, "R6");
    // R7: capture with mode high and no update leaves par_out alone
    step(0, 1, 0, 1, 8'h5A, 0, "R7");
    step(0, 0, 0, 1, 8'hA5, 0, "R7");
    step(0, 0, 1, 1, 8'hA5, 0, "R6");
    step(0, 0, 0, 1, 8'h00, 0, "R6");
    @(negedge tck);
    #2;
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R3 queue actual=%0d expected=0", q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule